// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives a peripheral clock-enable from its parent clock. Software writes a divide ratio into a small divisor field and switches the output on or off with a separate enable bit. The output `clk_en_out` is a pulse train: high for one parent cycle in every N cycles, where N is decoded from the divisor field. Logic downstream uses it as a clock enable rather than as a clock.

The divisor field is five bits wide by default. A build option widens it to six bits, and in that width the top bit switches in a fixed divide-by-64 prescaler. A field of zero always selects the largest ratio. A divisor write does not take effect at once. It passes through a short synchronisation delay, during which a busy flag is visible in the status word. The counter picks up the new ratio only when its current period ends, so no period is ever cut short.

Top module: `clkdiv_gated`

## Requirements
- R1: After reset, the enable bit, both busy bits and the divisor readback are zero, and `clk_en_out` is low.
- R2: In the default 5-bit build, a field value v in 1..31 gives one output pulse every v parent cycles, and v = 0 gives one pulse every 32 cycles.
- R3: In the 6-bit build, with field bit 5 clear, a value v in 1..31 gives a period of v cycles, and v = 0 gives a period of 64 cycles.
- R4: In the 6-bit build, with field bit 5 set, the period is 64 times the low five bits, and low bits of zero give a period of 64.
- R5: Reading address 0 returns busy on bits 3 and 4. Both bits are set from the cycle after an accepted divisor write (address 1) and clear exactly SYNC_LAT cycles after that write; the default SYNC_LAT is 3.
- R6: Bit 0 at address 0 is the enable, which is writable and reads back. While it is clear, `clk_en_out` stays low. The first pulse appears in the cycle after the enable is set. Writing the enable leaves the divisor readback unchanged.
- R7: A divisor write with any bit set above the field width is dropped. The readback keeps its old value and busy does not rise.
- R8: A new ratio takes effect only at a period boundary, so every observed gap between pulses equals either the old ratio or the new one.
- R9: A ratio of 1 keeps `clk_en_out` high on every parent cycle.
- R10: Reading address 1 returns the last accepted divisor value, starting in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control/status, 1 divisor |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register, combinational |
| clk_en_out | output | 1 | Gated divided clock-enable pulse |

## Verification
A bad down-counter value or a bad decoded ratio shows up as a wrong gap between two pulses. The bench measures these gaps directly, so such a fault is seen within one output period of the faulty state, which is at most 1984 cycles in the wide build. If a commit is early or late, the error appears at the busy bits, counted cycle by cycle after the write. A commit that bypasses the period boundary shows up as a gap that matches neither the old ratio nor the new one. A bad enable gate breaks the rule of a first pulse in the cycle after enabling and silence after disabling, which is visible in the very next sample.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_DIV  = 1'b1
   } regsel_e;

   localparam int ENABLE_POS = 0;
   localparam int BUSY_POS_A = 3;
   localparam int BUSY_POS_B = 4;
   localparam int PRESCALE_SHIFT = 6;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int FW       = 5,
   parameter int DW       = 8,
   parameter int SYNC_LAT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          en_q,
   output logic          busy,
   output logic [FW-1:0] pend_q,
   output logic [FW-1:0] act_q
);
   localparam int LW = $clog2(SYNC_LAT + 1);

   logic [LW-1:0] lat_q;
   logic          sel_div;
   logic          sel_ctrl;
   logic          accept;

   assign sel_div  = regsel_e'(reg_addr) == SEL_DIV;
   assign sel_ctrl = regsel_e'(reg_addr) == SEL_CTRL;
   assign accept   = reg_wr && sel_div && (reg_wdata[DW-1:FW] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= '0;
         act_q  <= '0;
         lat_q  <= '0;
      end else begin
         if (reg_wr && sel_ctrl)
            en_q <= reg_wdata[ENABLE_POS];
         if (accept) begin
            pend_q <= reg_wdata[FW-1:0];
            lat_q  <= LW'(SYNC_LAT);
         end else if (lat_q != '0) begin
            lat_q <= lat_q - 1'b1;
            if (lat_q == LW'(1))
               act_q <= pend_q;
         end
      end
   end

   assign busy = lat_q != '0;

   always_comb begin
      reg_rdata = '0;
      if (sel_div) begin
         reg_rdata[FW-1:0] = pend_q;
      end else begin
         reg_rdata[ENABLE_POS] = en_q;
         reg_rdata[BUSY_POS_A] = busy;
         reg_rdata[BUSY_POS_B] = busy;
      end
   end
endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
   import clkdiv_pkg::*;
#(
   parameter bit WIDE_MODE = 1'b0,
   parameter int FW        = 5,
   parameter int CW        = 6
) (
   input  logic [FW-1:0] field,
   output logic [CW-1:0] ratio_m1
);
   localparam int MAX_RATIO = 1 << FW;

   generate
      if (WIDE_MODE) begin : g_wide
         logic [FW-2:0] low;
         assign low = field[FW-2:0];
         always_comb begin
            if (field[FW-1]) begin
               if (low == '0)
                  ratio_m1 = CW'(MAX_RATIO - 1);
               else
                  ratio_m1 = (CW'(low) << PRESCALE_SHIFT) - 1'b1;
            end else if (field == '0) begin
               ratio_m1 = CW'(MAX_RATIO - 1);
            end else begin
               ratio_m1 = CW'(field) - 1'b1;
            end
         end
      end else begin : g_narrow
         always_comb begin
            if (field == '0)
               ratio_m1 = CW'(MAX_RATIO - 1);
            else
               ratio_m1 = CW'(field) - 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [CW-1:0] ratio_m1,
   output logic [CW-1:0] cnt_q,
   output logic          pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n || !en)
         cnt_q <= '0;
      else if (cnt_q == '0)
         cnt_q <= ratio_m1;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   assign pulse = en && (cnt_q == '0);
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated #(
   parameter bit WIDE_MODE = 1'b0,
   parameter int DW        = 8,
   parameter int SYNC_LAT  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          clk_en_out
);
   localparam int FW = WIDE_MODE ? 6 : 5;
   localparam int CW = WIDE_MODE ? 11 : 6;

   generate
      if (SYNC_LAT < 2 || SYNC_LAT > 4) begin : g_bad_lat
         $error("clkdiv_gated: SYNC_LAT must lie in 2..4");
      end
      if (DW <= FW || DW < 5) begin : g_bad_dw
         $error("clkdiv_gated: DW must exceed the field width and hold the busy bits");
      end
   endgenerate

   logic          en_q;
   logic          busy;
   logic [FW-1:0] pend_q;
   logic [FW-1:0] act_q;
   logic [CW-1:0] ratio_m1;
   logic [CW-1:0] cnt_q;

   clkdiv_regs #(.FW(FW), .DW(DW), .SYNC_LAT(SYNC_LAT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .en_q      (en_q),
      .busy      (busy),
      .pend_q    (pend_q),
      .act_q     (act_q)
   );

   clkdiv_ratio #(.WIDE_MODE(WIDE_MODE), .FW(FW), .CW(CW)) u_ratio (
      .field    (act_q),
      .ratio_m1 (ratio_m1)
   );

   clkdiv_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .ratio_m1 (ratio_m1),
      .cnt_q    (cnt_q),
      .pulse    (clk_en_out)
   );
endmodule

// File: rtl/clkdiv_gated_chk.sv
module clkdiv_gated_chk #(
   parameter int FW       = 5,
   parameter int DW       = 8,
   parameter int CW       = 6,
   parameter int SYNC_LAT = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic          clk_en_out,
   input logic          en_q,
   input logic          busy,
   input logic [FW-1:0] pend_q,
   input logic [CW-1:0] cnt_q
);
   logic       acc;
   logic       bad;
   logic [2:0] age_q;

   assign acc = reg_wr && reg_addr && (reg_wdata[DW-1:FW] == '0);
   assign bad = reg_wr && reg_addr && (reg_wdata[DW-1:FW] != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         age_q <= 3'd7;
      else if (acc)
         age_q <= 3'd0;
      else if (age_q != 3'd7)
         age_q <= age_q + 3'd1;
   end

   a_r5_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy);

   a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (age_q < 3'(SYNC_LAT)));

   a_r7_illegal_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !busy) |=> ($stable(pend_q) && !busy));

   a_r6_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> clk_en_out);

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cnt_q != '0) |=> ((cnt_q == CW'($past(cnt_q) - 1'b1)) || !en_q));
endmodule

bind clkdiv_gated clkdiv_gated_chk #(
   .FW(FW), .DW(DW), .CW(CW), .SYNC_LAT(SYNC_LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .clk_en_out (clk_en_out),
   .en_q       (en_q),
   .busy       (busy),
   .pend_q     (pend_q),
   .cnt_q      (cnt_q)
);

// File: tb/clkdiv_gated_test.sv
module clkdiv_gated_test;
   localparam int LAT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_n = 1'b0;
   logic       wr_w = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rd_n;
   logic [7:0] rd_w;
   logic       tk_n;
   logic       tk_w;
   int         errs = 0;
   int         checks = 0;

   always #5 clk = ~clk;

   clkdiv_gated #(.WIDE_MODE(1'b0), .DW(8), .SYNC_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_n), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rd_n), .clk_en_out(tk_n));

   clkdiv_gated #(.WIDE_MODE(1'b1), .DW(8), .SYNC_LAT(LAT)) uut_wide (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr_w), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rd_w), .clk_en_out(tk_w));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_ratio(input bit w, input int v);
      if (!w) return (v == 0) ? 32 : v;
      if (v >= 32) return ((v - 32) == 0) ? 64 : 64 * (v - 32);
      return (v == 0) ? 64 : v;
   endfunction

   function automatic bit tick(input bit w);
      return w ? tk_w : tk_n;
   endfunction

   task automatic wr(input bit w, input bit a, input int d);
      @(negedge clk);
      addr = a; wdata = d[7:0]; wr_n = !w; wr_w = w;
      @(negedge clk);
      wr_n = 1'b0; wr_w = 1'b0;
   endtask

   task automatic rd(input bit w, input bit a, output int d);
      addr = a;
      #1;
      d = w ? int'(rd_w) : int'(rd_n);
   endtask

   task automatic set_div(input bit w, input int v);
      wr(w, 1'b1, v);
      repeat (LAT + 1) @(negedge clk);
   endtask

   task automatic measure(input bit w, output int gap);
      int n;
      n = 0;
      do begin @(negedge clk); n++; end while (!tick(w) && n < 5000);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick(w) && gap < 5000);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int d, g, v, rnd, last;
      bit ok;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, 1'b0, d); chk(d == 0, "R1 ctrl/status", d, 0);
      rd(1'b0, 1'b1, d); chk(d == 0, "R1 divisor", d, 0);
      chk(!tk_n && !tk_w, "R1 output low", int'(tk_n | tk_w), 0);

      // R6 first pulse right after enable; R2 zero field -> 32
      wr(1'b0, 1'b0, 1);
      chk(tk_n == 1'b1, "R6 first pulse", int'(tk_n), 1);
      rd(1'b0, 1'b0, d); chk(d[0] == 1'b1, "R6 enable readback", d[0], 1);
      measure(1'b0, g); chk(g == 32, "R2 zero field", g, 32);

      // R5 busy window, R10 readback
      wr(1'b0, 1'b1, 5);
      rd(1'b0, 1'b0, d); chk(d[4:3] == 2'b11, "R5 busy after write", d[4:3], 3);
      rd(1'b0, 1'b1, d); chk(d == 5, "R10 divisor readback", d, 5);
      for (int i = 1; i < LAT; i++) begin
         @(negedge clk);
         rd(1'b0, 1'b0, d); chk(d[4:3] == 2'b11, "R5 busy held", d[4:3], 3);
      end
      @(negedge clk);
      rd(1'b0, 1'b0, d); chk(d[4:3] == 2'b00, "R5 busy cleared", d[4:3], 0);
      measure(1'b0, g); chk(g == 5, "R2 ratio 5", g, 5);

      // R9 ratio one
      set_div(1'b0, 1);
      ok = 1'b1;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (!tk_n) ok = 1'b0; end
      chk(ok, "R9 every cycle", int'(ok), 1);

      // R7 illegal narrow write
      wr(1'b0, 1'b1, 8'h25);
      rd(1'b0, 1'b0, d); chk(d[4:3] == 2'b00, "R7 no busy", d[4:3], 0);
      rd(1'b0, 1'b1, d); chk(d == 1, "R7 readback kept", d, 1);

      // R2 random ratios
      for (int i = 0; i < 6; i++) begin
         v = $urandom_range(31, 1);
         set_div(1'b0, v);
         measure(1'b0, g); chk(g == exp_ratio(1'b0, v), "R2 random ratio", g, exp_ratio(1'b0, v));
      end

      // R8 change mid-period
      set_div(1'b0, 10);
      measure(1'b0, g);
      rnd = $urandom_range(6, 0);
      repeat (rnd) @(negedge clk);
      wr(1'b0, 1'b1, 3);
      ok = 1'b1; last = 0;
      for (int k = 0; k < 6; k++) begin
         g = 0;
         do begin @(negedge clk); g++; end while (!tk_n && g < 100);
         if (k > 0 && g != 10 && g != 3) ok = 1'b0;
         last = g;
      end
      chk(ok, "R8 gaps old or new", int'(ok), 1);
      chk(last == 3, "R8 new ratio applied", last, 3);

      // R6 disable gating
      wr(1'b0, 1'b0, 0);
      ok = 1'b1;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (tk_n) ok = 1'b0; end
      chk(ok, "R6 disabled silent", int'(ok), 1);
      rd(1'b0, 1'b1, d); chk(d == 3, "R6 divisor untouched", d, 3);

      // Wide build: R3, R4
      wr(1'b1, 1'b0, 1);
      measure(1'b1, g); chk(g == 64, "R3 zero field", g, 64);
      set_div(1'b1, 7);
      measure(1'b1, g); chk(g == 7, "R3 ratio 7", g, 7);
      set_div(1'b1, 8'h20);
      measure(1'b1, g); chk(g == 64, "R4 prescale zero low", g, 64);
      set_div(1'b1, 8'h23);
      measure(1'b1, g); chk(g == 192, "R4 prescale x3", g, 192);

      // R7 illegal wide write
      wr(1'b1, 1'b1, 8'h45);
      rd(1'b1, 1'b0, d); chk(d[4:3] == 2'b00, "R7 wide no busy", d[4:3], 0);
      rd(1'b1, 1'b1, d); chk(d == 8'h23, "R7 wide readback kept", d, 8'h23);

      for (int i = 0; i < 4; i++) begin
         v = $urandom_range(63, 0);
         set_div(1'b1, v);
         measure(1'b1, g);
         chk(g == exp_ratio(1'b1, v), (v >= 32) ? "R4 random" : "R3 random", g, exp_ratio(1'b1, v));
      end

      summary();
      $finish;
   end
endmodule